// File: doc/BRIEF.md
# Clocked Serial Transceiver With Overrun Detection

This block moves bytes over a two-wire link made of one clock line and one data line that is shared by both directions. A single shift register does the bit work. A transmit holding register and a receive holding register sit beside it, so software can queue the next outgoing byte, or collect the last incoming one, while a byte is still shifting. When it is the clock master, the block divides its system clock to make the line clock and drives that clock out. As a slave it follows the clock it finds on the line, after synchronising it.

The direction of the data line is a static mode. In transmit mode the block drives the data line. In receive mode it only samples it. Outgoing data changes on the falling edge of the line clock, and incoming data is sampled on the rising edge. Bit order is selectable, with the most significant bit first or the least significant bit first. Four status flags cover transmit-holding empty, transmit end, receive full and overrun. Each flag has its own enable bit, and the enabled flags are combined onto one registered interrupt line.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset the status vector is 4'b0001 (bit 0 holding-empty set; bits 1 transmit-end, 2 receive-full, 3 overrun clear), irq is 0, rx_data is 0 and sck_o is 1.
- R2: With master_en=1 the line clock toggles every HALF_DIV system clocks while a byte is shifting or queued, stays high when there is nothing to send, and sck_oe equals master_en.
- R3: In transmit mode sd_o changes only after a falling edge of the line clock and is stable at the rising edge; with lsb_first=0 the byte leaves bit 7 first.
- R4: With lsb_first=1 a transmitted byte leaves bit 0 first and a received byte takes its first line bit as bit 0.
- R5: In receive mode, sd_i is sampled on each rising edge; after the eighth rising edge rx_data holds the byte (first bit as bit 7 when lsb_first=0) and receive-full (bit 2) is set.
- R6: Writing tx_data with tx_wr clears holding-empty (bit 0), which is set again when the byte moves into the shift register. A byte queued before the current one ends follows with no idle clock period.
- R7: Transmit-end (bit 1) is set when the eighth bit has shifted out and the holding register is empty. It stays clear while a queued byte follows. A tx_wr clears it.
- R8: If the eighth bit of a byte arrives while receive-full is set and rx_rd is not asserted, overrun (bit 3) is set and rx_data keeps the unread byte. A pulse on ovr_clr clears overrun.
- R9: A pulse on rx_rd clears receive-full.
- R10: irq is 1 one clock after any status bit n is 1 while irq_en[n] is 1 (the bit map is shared with the status vector), and 0 when no enabled bit is set.
- R11: With master_en=0 the block shifts on the synchronised external sck_i edges and drives sck_oe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| master_en | input | 1 | 1: internal divided clock, 0: external clock |
| mode_tx | input | 1 | 1: transmit (drive data line), 0: receive |
| lsb_first | input | 1 | Bit order select |
| rx_run | input | 1 | Master receive: keep the clock running |
| irq_en | input | 4 | Per-flag interrupt enables |
| tx_wr | input | 1 | Write strobe for tx_data |
| tx_data | input | DATA_W | Byte to queue for sending |
| rx_rd | input | 1 | Read acknowledge for rx_data |
| ovr_clr | input | 1 | Clears overrun |
| rx_data | output | DATA_W | Receive holding register |
| status | output | 4 | {overrun, receive-full, transmit-end, holding-empty} |
| irq | output | 1 | Combined interrupt |
| sck_i | input | 1 | Clock line input |
| sck_o | output | 1 | Clock line output value |
| sck_oe | output | 1 | Clock line output enable |
| sd_i | input | 1 | Data line input |
| sd_o | output | 1 | Data line output value |
| sd_oe | output | 1 | Data line output enable |

## Verification
Back-to-back transmission is driven by queueing the second byte as soon as holding-empty returns. A design that left a gap, or raised transmit-end between the bytes, would show an uneven rising-edge interval or a premature flag. Overrun is provoked by receiving a second byte without reading the first. A design that overwrote the holding register, or missed the flag, would change rx_data or leave bit 3 clear. Both bit orders are run in each direction, so a reversed shift or a mirrored capture shows up as a bit-swapped byte. Interrupt masking is tested by dropping an enable while its flag stays set.

// File: rtl/serx_pkg.sv
package serx_pkg;
  localparam int unsigned NUM_SRC = 4;

  // bit 0 holding-empty, bit 1 transmit-end, bit 2 receive-full, bit 3 overrun
  typedef struct packed {
    logic ovr;
    logic rfull;
    logic tend;
    logic tempty;
  } serx_flags_t;
endpackage

// File: rtl/serx_clkgen.sv
module serx_clkgen #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic master,
  input  logic run_req,
  input  logic sck_in,
  input  logic sd_in,
  output logic fall_stb,
  output logic rise_stb,
  output logic sck_out,
  output logic sd_sync
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [2:0] sck_sh;
  logic [1:0] sd_sh;
  logic [DIV_W-1:0] div_cnt;
  logic sck_q;
  logic active;
  logic tick;
  logic ext_fall;
  logic ext_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_sh <= 3'b111;
      sd_sh  <= 2'b00;
    end else begin
      sck_sh <= {sck_sh[1:0], sck_in};
      sd_sh  <= {sd_sh[0], sd_in};
    end
  end

  assign ext_fall = sck_sh[2] & ~sck_sh[1];
  assign ext_rise = ~sck_sh[2] & sck_sh[1];
  assign sd_sync  = sd_sh[1];

  assign active = run_req | ~sck_q;
  assign tick   = master & active & (div_cnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt <= '0;
      sck_q   <= 1'b1;
    end else if (!master || !active) begin
      div_cnt <= '0;
      sck_q   <= 1'b1;
    end else if (tick) begin
      div_cnt <= '0;
      sck_q   <= ~sck_q;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  assign fall_stb = master ? (tick & sck_q)  : ext_fall;
  assign rise_stb = master ? (tick & ~sck_q) : ext_rise;
  assign sck_out  = sck_q;

  // R2: with no work the master clock holds high
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    (master && !run_req && sck_q) |=> sck_q);
  // R11: in slave mode the internal clock output never leaves high
  p_slave_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !master |=> sck_q);
endmodule

// File: rtl/serx_shifter.sv
module serx_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fall_stb,
  input  logic              rise_stb,
  input  logic              mode_tx,
  input  logic              lsb_first,
  input  logic              sd_in,
  input  logic [DATA_W-1:0] tx_word,
  output logic              load_stb,
  output logic              done_stb,
  output logic              busy,
  output logic [DATA_W-1:0] rx_word,
  output logic              sd_out
);
  localparam int unsigned CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] sr;
  logic [DATA_W-1:0] sr_next;
  logic [CNT_W-1:0]  bit_cnt;
  logic              busy_q;
  logic              sd_q;

  assign sr_next  = lsb_first ? {sd_in, sr[DATA_W-1:1]} : {sr[DATA_W-2:0], sd_in};
  assign load_stb = fall_stb & ~busy_q & mode_tx;
  assign done_stb = rise_stb & busy_q & (bit_cnt == BIT_LAST);
  assign rx_word  = sr_next;
  assign busy     = busy_q;
  assign sd_out   = sd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr      <= '0;
      bit_cnt <= '0;
      busy_q  <= 1'b0;
      sd_q    <= 1'b1;
    end else if (fall_stb) begin
      if (!busy_q) begin
        busy_q  <= 1'b1;
        bit_cnt <= '0;
        if (mode_tx) begin
          sr   <= tx_word;
          sd_q <= lsb_first ? tx_word[0] : tx_word[DATA_W-1];
        end
      end else begin
        sd_q <= lsb_first ? sr[0] : sr[DATA_W-1];
      end
    end else if (rise_stb && busy_q) begin
      sr      <= sr_next;
      bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt == BIT_LAST) busy_q <= 1'b0;
    end
  end

  // R5: an idle shifter always starts the next byte from bit zero
  p_idle_count_r5: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (bit_cnt == '0));
  // R3: data output only moves on a falling strobe
  p_out_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !fall_stb |=> $stable(sd_q));
  // R6: finishing a byte always leaves the shifter idle
  p_done_idle_r6: assert property (@(posedge clk) disable iff (rst)
    done_stb |=> !busy_q);
endmodule

// File: rtl/serx_status.sv
module serx_status
  import serx_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tx_wr,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               rx_rd,
  input  logic               ovr_clr,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               mode_tx,
  input  logic               load_stb,
  input  logic               done_stb,
  input  logic [DATA_W-1:0]  rx_word,
  output serx_flags_t        flags,
  output logic [DATA_W-1:0]  tx_hold,
  output logic [DATA_W-1:0]  rx_hold,
  output logic               irq
);
  serx_flags_t       fl;
  logic [DATA_W-1:0] txh;
  logic [DATA_W-1:0] rxh;
  logic              irq_q;
  logic              rx_done;
  logic              rfull_live;

  assign rx_done    = done_stb & ~mode_tx;
  assign rfull_live = fl.rfull & ~rx_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      fl    <= '{ovr: 1'b0, rfull: 1'b0, tend: 1'b0, tempty: 1'b1};
      txh   <= '0;
      rxh   <= '0;
      irq_q <= 1'b0;
    end else begin
      if (tx_wr) begin
        txh       <= tx_data;
        fl.tempty <= 1'b0;
        fl.tend   <= 1'b0;
      end else begin
        if (load_stb) fl.tempty <= 1'b1;
        if (done_stb && mode_tx && fl.tempty) fl.tend <= 1'b1;
      end

      if (rx_done) begin
        if (rfull_live) begin
          fl.ovr <= 1'b1;
        end else begin
          rxh      <= rx_word;
          fl.rfull <= 1'b1;
        end
      end else if (rx_rd) begin
        fl.rfull <= 1'b0;
      end

      if (!(rx_done && rfull_live) && ovr_clr) fl.ovr <= 1'b0;

      irq_q <= |(fl & irq_en);
    end
  end

  assign flags   = fl;
  assign tx_hold = txh;
  assign rx_hold = rxh;
  assign irq     = irq_q;

  // R6: a write always leaves the holding register full
  p_write_fills_r6: assert property (@(posedge clk) disable iff (rst)
    tx_wr |=> !fl.tempty);
  // R7: transmit-end only appears with an empty holding register
  p_end_needs_empty_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fl.tend) |-> fl.tempty);
  // R8: a byte landing on unread data flags overrun and keeps the old byte
  p_overrun_keeps_r8: assert property (@(posedge clk) disable iff (rst)
    (rx_done && fl.rfull && !rx_rd) |=> (fl.ovr && $stable(rxh)));
  // R10: interrupt only follows an enabled flag of the previous cycle
  p_irq_source_r10: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(|(fl & irq_en)));
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import serx_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HALF_DIV = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               master_en,
  input  logic               mode_tx,
  input  logic               lsb_first,
  input  logic               rx_run,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               tx_wr,
  input  logic [DATA_W-1:0]  tx_data,
  input  logic               rx_rd,
  input  logic               ovr_clr,
  output logic [DATA_W-1:0]  rx_data,
  output logic [NUM_SRC-1:0] status,
  output logic               irq,
  input  logic               sck_i,
  output logic               sck_o,
  output logic               sck_oe,
  input  logic               sd_i,
  output logic               sd_o,
  output logic               sd_oe
);
  serx_flags_t       flags;
  logic [DATA_W-1:0] tx_hold;
  logic [DATA_W-1:0] rx_word;
  logic              fall_stb;
  logic              rise_stb;
  logic              load_stb;
  logic              done_stb;
  logic              busy;
  logic              sd_sync;
  logic              run_req;

  assign run_req = busy | (mode_tx ? ~flags.tempty : rx_run);

  serx_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk      (clk),
    .rst      (rst),
    .master   (master_en),
    .run_req  (run_req),
    .sck_in   (sck_i),
    .sd_in    (sd_i),
    .fall_stb (fall_stb),
    .rise_stb (rise_stb),
    .sck_out  (sck_o),
    .sd_sync  (sd_sync)
  );

  serx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk       (clk),
    .rst       (rst),
    .fall_stb  (fall_stb),
    .rise_stb  (rise_stb),
    .mode_tx   (mode_tx),
    .lsb_first (lsb_first),
    .sd_in     (sd_sync),
    .tx_word   (tx_hold),
    .load_stb  (load_stb),
    .done_stb  (done_stb),
    .busy      (busy),
    .rx_word   (rx_word),
    .sd_out    (sd_o)
  );

  serx_status #(.DATA_W(DATA_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .tx_wr    (tx_wr),
    .tx_data  (tx_data),
    .rx_rd    (rx_rd),
    .ovr_clr  (ovr_clr),
    .irq_en   (irq_en),
    .mode_tx  (mode_tx),
    .load_stb (load_stb),
    .done_stb (done_stb),
    .rx_word  (rx_word),
    .flags    (flags),
    .tx_hold  (tx_hold),
    .rx_hold  (rx_data),
    .irq      (irq)
  );

  assign status = flags;
  assign sck_oe = master_en;
  assign sd_oe  = mode_tx;
endmodule

// File: tb/sync_serial_xcvr_bench.sv
module sync_serial_xcvr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 3;
  localparam int SLV_HALF = 5;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       master_en = 1'b1, mode_tx = 1'b1, lsb_first = 1'b0, rx_run = 1'b0;
  logic [3:0] irq_en = 4'b0000;
  logic       tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [7:0] rx_data;
  logic [3:0] status;
  logic       irq, sck_i = 1'b1, sck_o, sck_oe, sd_i = 1'b0, sd_o, sd_oe;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;

  sync_serial_xcvr #(.DATA_W(8), .HALF_DIV(HALF)) u_sync_serial_xcvr (
    .clk(clk), .rst(rst), .master_en(master_en), .mode_tx(mode_tx),
    .lsb_first(lsb_first), .rx_run(rx_run), .irq_en(irq_en), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .ovr_clr(ovr_clr), .rx_data(rx_data),
    .status(status), .irq(irq), .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .sd_i(sd_i), .sd_o(sd_o), .sd_oe(sd_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_wr(input logic [7:0] b);
    tx_data = b; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  // Collect n bits at rising edges of sck_o; returns bits in line order
  task automatic grab_master(input int n, output logic [15:0] bits,
                             output bit gap_ok, output bit stable_ok,
                             output logic [3:0] st_mid);
    logic prev_sck, prev_sd;
    int last, got, guard;
    bits = '0; gap_ok = 1'b1; stable_ok = 1'b1; st_mid = '0;
    got = 0; last = -1; guard = 0;
    prev_sck = sck_o; prev_sd = sd_o;
    while (got < n && guard < 2000) begin
      @(negedge clk);
      guard++;
      if (!prev_sck && sck_o) begin
        bits[got] = sd_o;
        if (sd_o !== prev_sd) stable_ok = 1'b0;
        if (last >= 0 && (guard - last) != 2*HALF) gap_ok = 1'b0;
        last = guard;
        got++;
        if (got == 8) st_mid = status;
      end
      prev_sck = sck_o; prev_sd = sd_o;
    end
  endtask

  function automatic logic [7:0] order(input logic [7:0] line, input bit lsb);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[lsb ? i : 7-i] = line[i];
    return r;
  endfunction

  task automatic slave_rx(input logic [7:0] b, input bit lsb);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b0;
      sd_i = lsb ? b[i] : b[7-i];
      idle(SLV_HALF);
      sck_i = 1'b1;
      idle(SLV_HALF);
    end
    idle(6);
  endtask

  task automatic t_reset;
    chk(status == 4'b0001, "R1 status", status, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    chk(sck_o == 1'b1 && rx_data == 8'h00, "R1 sck_o/rx_data", {sck_o, rx_data}, 9'h100);
  endtask

  task automatic t_master_tx(input logic [7:0] b, input bit lsb);
    logic [15:0] bits; bit g, s; logic [3:0] m;
    master_en = 1'b1; mode_tx = 1'b1; lsb_first = lsb;
    idle(2);
    chk(sck_oe == 1'b1 && sd_oe == 1'b1, "R2 output enables", {sck_oe, sd_oe}, 3);
    pulse_wr(b);
    grab_master(8, bits, g, s, m);
    chk(order(bits[7:0], lsb) == b, lsb ? "R4 lsb-first tx byte" : "R3 msb-first tx byte",
        order(bits[7:0], lsb), b);
    chk(g, "R2 half period", g, 1);
    chk(s, "R3 data stable at rise", s, 1);
    idle(6*HALF);
    chk(sck_o == 1'b1, "R2 clock idles high", sck_o, 1);
    chk(status[1:0] == 2'b11, "R7 transmit-end with empty holding", status[1:0], 3);
  endtask

  task automatic t_back_to_back;
    logic [15:0] bits; bit g, s; logic [3:0] m; int guard;
    master_en = 1'b1; mode_tx = 1'b1; lsb_first = 1'b0;
    pulse_wr(8'h5A);
    chk(status[1:0] == 2'b00, "R7 write clears end and empty", status[1:0], 0);
    guard = 0;
    while (status[0] == 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    chk(status[0] == 1'b1, "R6 empty after load", status[0], 1);
    pulse_wr(8'hC1);
    grab_master(16, bits, g, s, m);
    chk(order(bits[7:0], 0) == 8'h5A && order(bits[15:8], 0) == 8'hC1, "R6 two bytes",
        {order(bits[15:8], 0), order(bits[7:0], 0)}, 16'hC15A);
    chk(g, "R6 no gap between bytes", g, 1);
    chk(m[1] == 1'b0, "R7 no end while byte queued", m[1], 0);
    idle(6*HALF);
    chk(status[1] == 1'b1, "R7 end after last byte", status[1], 1);
  endtask

  task automatic t_slave_rx;
    master_en = 1'b0; mode_tx = 1'b0; lsb_first = 1'b0; irq_en = 4'b0100;
    idle(2);
    chk(sck_oe == 1'b0 && sd_oe == 1'b0, "R11 slave enables", {sck_oe, sd_oe}, 0);
    slave_rx(8'h96, 1'b0);
    chk(rx_data == 8'h96, "R5 msb-first rx byte", rx_data, 8'h96);
    chk(status[2] == 1'b1, "R5 receive-full", status[2], 1);
    chk(irq == 1'b1, "R10 irq on enabled receive-full", irq, 1);
    irq_en = 4'b0000;
    idle(2);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
  endtask

  task automatic t_overrun;
    irq_en = 4'b1000;
    slave_rx(8'h11, 1'b0);
    chk(status[3] == 1'b1, "R8 overrun set", status[3], 1);
    chk(rx_data == 8'h96, "R8 unread byte kept", rx_data, 8'h96);
    chk(irq == 1'b1, "R10 irq on overrun", irq, 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0;
    idle(1);
    chk(status[3] == 1'b0, "R8 overrun cleared", status[3], 0);
    rx_rd = 1'b1; @(negedge clk); rx_rd = 1'b0;
    chk(status[2] == 1'b0, "R9 read clears receive-full", status[2], 0);
    irq_en = 4'b0000;
    lsb_first = 1'b1;
    slave_rx(8'h2D, 1'b1);
    chk(rx_data == 8'h2D && status[3] == 1'b0, "R4 lsb-first rx byte", rx_data, 8'h2D);
  endtask

  task automatic t_slave_tx;
    logic [7:0] got;
    master_en = 1'b0; mode_tx = 1'b1; lsb_first = 1'b0;
    pulse_wr(8'hC3);
    for (int i = 0; i < 8; i++) begin
      sck_i = 1'b0;
      idle(SLV_HALF);
      got[7-i] = sd_o;
      sck_i = 1'b1;
      idle(SLV_HALF);
    end
    idle(6);
    chk(got == 8'hC3, "R11 slave tx on external clock", got, 8'hC3);
    chk(status[1:0] == 2'b11, "R7 end in slave tx", status[1:0], 3);
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_master_tx(8'hA5, 1'b0);
    t_master_tx(8'h3C, 1'b1);
    t_back_to_back();
    t_slave_rx();
    t_overrun();
    t_slave_tx();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule